// File: doc/BRIEF.md
# Pipelined Doubleword Lane Shuffle

This block rearranges the four 32-bit lanes of a 128-bit vector under an 8-bit order control. Each result lane is filled from whichever source lane its 2-bit selector names. Several result lanes may name the same source lane, so broadcasts and partial duplications come out as naturally as permutations.

The source is taken from one of two 128-bit buses: a register-file value or a memory-read value. A select input picks between them. The unit has two register stages and accepts a new operation on every clock. A valid bit and a destination-register tag travel with each operation and leave the unit together with its result. The unit has no status outputs.

Top module: `dword_lane_shuffle`

## Requirements
- R1: While `rst` is high at a rising clock edge, every pipeline valid bit clears, so `out_valid` is low after that edge.
- R2: `out_valid` equals the value `in_valid` had at the rising edge two cycles earlier. A low `in_valid` produces a bubble two cycles later.
- R3: Result lane n, which is `out_data[32n+31:32n]`, is controlled by `order[2n+1:2n]`. Bits [1:0] control lane 0, [3:2] lane 1, [5:4] lane 2 and [7:6] lane 3.
- R4: A selector value k (0 to 3) places source lane k, which is source bits [32k+31:32k], into its result lane. This equals the source shifted right by 32·k bits and cut to 32 bits.
- R5: Selectors need not be unique. Order 0x00 fills all four result lanes with source lane 0, and 0xFF fills them with lane 3.
- R6: With `src_is_mem` = 1 the source is `mem_src`. With `src_is_mem` = 0 the source is `reg_src`. The unselected bus has no effect on the result.
- R7: `out_tag` carries the `dst_tag` of the same operation, with the same two-cycle latency as the data.
- R8: A new operation is accepted on every cycle. Back-to-back operations come out on consecutive cycles, in order and without interference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| src_is_mem | input | 1 | 1 selects mem_src, 0 selects reg_src |
| reg_src | input | 128 | Register-file source vector |
| mem_src | input | 128 | Memory-read source vector |
| order | input | 8 | Four 2-bit lane selectors |
| dst_tag | input | TAG_W (6) | Destination register tag |
| out_valid | output | 1 | Result is valid |
| out_data | output | 128 | Shuffled vector |
| out_tag | output | TAG_W (6) | Tag of the result |

## Verification
Two functions can act in the same cycle: a new operation entering the source mux while an older one is being shuffled in the lane stage, and an operation leaving while a bubble enters. The bench provokes this with all 256 order values presented back to back, each with a fresh source. The source bus alternates between register and memory, and each bus that is not selected is filled with different data. It then runs a long random stream with bubbles mixed in. A behavioural queue model, two entries deep, is compared against valid, data and tag on every clock. A result that is off by one cycle, or that picked up data from a neighbouring operation, therefore shows up as a mismatch.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 32;
  localparam int SEL_W  = $clog2(LANES);
  localparam int ORD_W  = LANES * SEL_W;
  localparam int VEC_W  = LANES * LANE_W;

  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [ORD_W-1:0]  ord_t;

  // Picks source lane `sel` from a packed vector.
  function automatic lane_t pick_lane(vec_t v, sel_t sel);
    return v[sel*LANE_W +: LANE_W];
  endfunction

  // Selector that controls result lane `n`.
  function automatic sel_t lane_selector(ord_t o, int n);
    return o[n*SEL_W +: SEL_W];
  endfunction
endpackage

// File: rtl/shuf_src_sel.sv
module shuf_src_sel
  import shuf_pkg::*;
(
  input  logic use_mem,
  input  vec_t reg_vec,
  input  vec_t mem_vec,
  output vec_t src_vec
);
  always_comb begin
    if (use_mem) src_vec = mem_vec;
    else         src_vec = reg_vec;
  end
endmodule

// File: rtl/shuf_lane_xbar.sv
module shuf_lane_xbar
  import shuf_pkg::*;
(
  input  vec_t src_vec,
  input  ord_t ord,
  output vec_t res_vec
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    sel_t  sel_n;
    lane_t lane_n;
    always_comb begin
      sel_n  = lane_selector(ord, n);
      lane_n = pick_lane(src_vec, sel_n);
    end
    assign res_vec[n*LANE_W +: LANE_W] = lane_n;
  end
endmodule

// File: rtl/shuf_stage_reg.sv
module shuf_stage_reg #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_vld,
  output logic [PAY_W-1:0] out_pay
);
  // Only the valid bit is reset; the payload is plain data.
  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    out_pay <= in_pay;
  end
endmodule

// File: rtl/dword_lane_shuffle.sv
module dword_lane_shuffle
  import shuf_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             src_is_mem,
  input  logic [127:0]     reg_src,
  input  logic [127:0]     mem_src,
  input  logic [7:0]       order,
  input  logic [TAG_W-1:0] dst_tag,
  output logic             out_valid,
  output logic [127:0]     out_data,
  output logic [TAG_W-1:0] out_tag
);
  localparam int S1_W = VEC_W + ORD_W + TAG_W;
  localparam int S2_W = VEC_W + TAG_W;

  // Stage 0: source selection.
  vec_t muxed_src;
  shuf_src_sel u_sel (
    .use_mem (src_is_mem),
    .reg_vec (reg_src),
    .mem_vec (mem_src),
    .src_vec (muxed_src)
  );

  // Stage 1 register: selected source, order and tag.
  logic             vld_s1;
  logic [S1_W-1:0]  pay_s1;
  vec_t             src_s1;
  ord_t             ord_s1;
  logic [TAG_W-1:0] tag_s1;

  shuf_stage_reg #(.PAY_W(S1_W)) u_s1 (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_valid),
    .in_pay  ({muxed_src, order, dst_tag}),
    .out_vld (vld_s1),
    .out_pay (pay_s1)
  );
  assign {src_s1, ord_s1, tag_s1} = pay_s1;

  // Lane crossbar.
  vec_t shuf_s1;
  shuf_lane_xbar u_xbar (
    .src_vec (src_s1),
    .ord     (ord_s1),
    .res_vec (shuf_s1)
  );

  // Stage 2 register: result and tag.
  logic [S2_W-1:0] pay_s2;
  shuf_stage_reg #(.PAY_W(S2_W)) u_s2 (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (vld_s1),
    .in_pay  ({shuf_s1, tag_s1}),
    .out_vld (out_valid),
    .out_pay (pay_s2)
  );
  assign {out_data, out_tag} = pay_s2;

  // Named events for the assertions.
  logic [1:0] warm_cnt;
  logic       warm;
  always_ff @(posedge clk) begin
    if (rst)              warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd2);

  logic dup_01_s1;
  assign dup_01_s1 = vld_s1 && (ord_s1[1:0] == ord_s1[3:2]);

  assert_rst_clear_R1: assert property (@(posedge clk)
    rst |=> (!vld_s1 && !out_valid));

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_valid == $past(in_valid, 2)));

  assert_dup_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    dup_01_s1 |=> (out_data[31:0] == out_data[63:32]));

  assert_mux_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_is_mem) |=> (src_s1 == $past(mem_src)));

  assert_tag_lat_R7: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid) |-> (out_tag == $past(dst_tag, 2)));
endmodule

// File: tb/tb_dword_lane_shuffle.sv
module tb_dword_lane_shuffle;
  localparam int TAG_W = 6;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             src_is_mem;
  logic [127:0]     reg_src;
  logic [127:0]     mem_src;
  logic [7:0]       order;
  logic [TAG_W-1:0] dst_tag;
  logic             out_valid;
  logic [127:0]     out_data;
  logic [TAG_W-1:0] out_tag;

  always #10 clk = ~clk;  // 50 MHz

  dword_lane_shuffle #(.TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_is_mem(src_is_mem),
    .reg_src(reg_src), .mem_src(mem_src), .order(order), .dst_tag(dst_tag),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
  );

  typedef struct {
    logic             v;
    logic [127:0]     d;
    logic [TAG_W-1:0] t;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Reference: each result lane is the source shifted right by 32*sel.
  function automatic logic [127:0] model(logic [127:0] s, logic [7:0] o);
    logic [127:0] r;
    logic [127:0] sh;
    int           k;
    for (int i = 0; i < 4; i++) begin
      k  = (o >> (2 * i)) & 3;
      sh = s >> (32 * k);
      r[32*i +: 32] = sh[31:0];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: compare the result due now, then present a new input.
  task automatic step(bit v, bit m, logic [127:0] rs, logic [127:0] ms,
                      logic [7:0] o, logic [TAG_W-1:0] t, string req);
    exp_t e;
    @(negedge clk);
    if (exp_q.size() == 2) begin
      e = exp_q.pop_front();
      check(out_valid == e.v, "R2", {127'b0, out_valid}, {127'b0, e.v});
      if (e.v) begin
        check(out_data == e.d, e.req, out_data, e.d);
        check(out_tag == e.t, "R7", {{(128-TAG_W){1'b0}}, out_tag},
              {{(128-TAG_W){1'b0}}, e.t});
      end
    end
    in_valid = v; src_is_mem = m; reg_src = rs; mem_src = ms;
    order = o; dst_tag = t;
    e.v = v;
    e.d = model(m ? ms : rs, o);
    e.t = t;
    e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] a;
    rst = 1'b1; in_valid = 1'b0; src_is_mem = 1'b0;
    reg_src = '0; mem_src = '0; order = '0; dst_tag = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", {127'b0, out_valid}, 128'd0);
    rst = 1'b0;

    // R3/R4/R8: every order value back to back, alternating source bus.
    for (int o = 0; o < 256; o++)
      step(1'b1, o[0], rand128(), rand128(), 8'(o), 6'(o), "R3");

    // R5: all-equal selectors.
    a = rand128();
    step(1'b1, 1'b0, a, rand128(), 8'h00, 6'd1, "R5");
    step(1'b1, 1'b1, rand128(), a, 8'hFF, 6'd2, "R5");
    step(1'b1, 1'b0, a, rand128(), 8'h55, 6'd3, "R5");
    step(1'b1, 1'b1, rand128(), a, 8'hAA, 6'd4, "R5");

    // R6: same selected source, different unselected bus.
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, a, rand128(), 8'h1B, 6'(i), "R6");
      step(1'b1, 1'b1, rand128(), a, 8'h1B, 6'(i + 8), "R6");
    end

    // R2/R7/R4: random stream with bubbles.
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) != 0, $urandom % 2, rand128(), rand128(),
           8'($urandom), 6'($urandom), "R4");

    // Drain.
    step(1'b0, 1'b0, '0, '0, '0, '0, "R2");
    step(1'b0, 1'b0, '0, '0, '0, '0, "R2");
    step(1'b0, 1'b0, '0, '0, '0, '0, "R2");

    // R1: reset with the pipeline full.
    step(1'b1, 1'b0, rand128(), '0, 8'hE4, 6'd5, "R1");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", {127'b0, out_valid}, 128'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule